// File: doc/BRIEF.md
# Bit-Serial Fuzzy Maximum/Minimum Operator

This block takes two fuzzy membership grades as bit streams, one bit of each operand per cycle, most significant bit first. On the same cycle it returns one bit of either the larger or the smaller of the two grades. The `mode` input picks which. Neither operand is stored. A small comparison tracker records whether the operands have matched so far, or which of them has already been shown to be larger. Each output bit is then taken from the operand that the chosen function favours.

An operation starts with a synchronous reset cycle. It then consumes `OP_W` valid bit pairs, so one operation occupies at least `OP_W + 1` cycles. A bit counter raises `done` during the cycle that carries the final valid bit. Cycles with `bit_valid` low are gaps in the stream and leave all state untouched. The grades use an unsigned code in which all-ones means full membership, so ordering by grade matches ordering by unsigned value.

Top module: `fzs_serial_maxmin`

## Requirements
- R1: While `rst` is high, the tracker returns to the equal state and the bit counter clears, whatever the other inputs are. During such a cycle `out_bit` and `done` are 0.
- R2: While every valid pair seen since reset has matched, the tracker stays in the equal state and `out_bit` equals the common bit of the current pair.
- R3: The first valid pair that differs sets the decision: a=1,b=0 means A is greater, and a=0,b=1 means A is less. After that, no later bit pair changes the decision until the next reset.
- R4: With `mode` = 0 (maximum), `out_bit` takes the B bit while equal, the A bit once A is greater, and the B bit once A is less. The stream is therefore the larger operand, MSB first.
- R5: With `mode` = 1 (minimum), `out_bit` takes the B bit once A is greater and the A bit once A is less. The stream is therefore the smaller operand, MSB first.
- R6: On the valid cycle of the first differing pair, `out_bit` already reflects the decision made from that pair: 1 for maximum and 0 for minimum. There is no cycle of latency.
- R7: `done` is high on exactly the cycle that carries the `OP_W`-th valid bit after reset, and only once. Further valid bits raise no new `done` and keep producing output from the held decision.
- R8: A cycle with `bit_valid` low changes neither the decision nor the bit count. During it, `out_bit` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; starts a new operation |
| a_bit | input | 1 | Current bit of operand A, MSB first |
| b_bit | input | 1 | Current bit of operand B, MSB first |
| mode | input | 1 | 0 selects maximum, 1 selects minimum |
| bit_valid | input | 1 | High when a_bit/b_bit carry a stream bit |
| out_bit | output | 1 | Current result bit, valid with bit_valid |
| done | output | 1 | High during the last valid bit of the operation |

## Verification
The assertions assume that `mode` stays fixed for the whole of an operation. They also assume that every operation begins with a reset cycle, so that the held decision and the bit count belong to one pair of operands. The stimulus respects both points. It drives `mode` and the operands only between reset pulses, and it changes inputs on the falling clock edge. Random gaps with `bit_valid` low are inserted inside operations. One extra valid bit after `done` is fed only when the operands differ, which keeps the expected decision unambiguous.

// File: rtl/fzs_pkg.sv
package fzs_pkg;

  // Comparison decision between the two streams seen so far.
  typedef enum logic [1:0] {
    CMP_EQ  = 2'b00,
    CMP_AGT = 2'b01,
    CMP_ALT = 2'b10
  } cmp_t;

  // Function selection: larger or smaller operand.
  typedef enum logic {
    SEL_MAX = 1'b0,
    SEL_MIN = 1'b1
  } sel_t;

  // Advance the decision by one MSB-first bit pair.
  function automatic cmp_t cmp_step(cmp_t cur, logic a, logic b);
    cmp_t nxt;
    nxt = cur;
    if (cur == CMP_EQ) begin
      if (a && !b)      nxt = CMP_AGT;
      else if (!a && b) nxt = CMP_ALT;
      else              nxt = CMP_EQ;
    end
    return nxt;
  endfunction

  // Choose which operand bit to forward for a given decision.
  function automatic logic pick_bit(sel_t sel, cmp_t d, logic a, logic b);
    logic r;
    unique case (d)
      CMP_AGT: r = (sel == SEL_MAX) ? a : b;
      CMP_ALT: r = (sel == SEL_MAX) ? b : a;
      default: r = b;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fzs_cmp_track.sv
module fzs_cmp_track
  import fzs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step_en,
  input  logic a_bit,
  input  logic b_bit,
  output cmp_t st_q,
  output cmp_t decide
);

  // Decision valid on this cycle: includes the current pair.
  always_comb begin
    decide = st_q;
    if (step_en) decide = cmp_step(st_q, a_bit, b_bit);
  end

  always_ff @(posedge clk) begin
    if (rst)          st_q <= CMP_EQ;
    else if (step_en) st_q <= decide;
  end

  // R2: matching pairs keep the tracker equal
  p_eq_stays_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q == CMP_EQ && step_en && a_bit == b_bit) |=> st_q == CMP_EQ);

  // R3: a made decision is held until reset
  p_decision_held_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q != CMP_EQ) |=> st_q == $past(st_q));

  // R3: a differing pair in the equal state leaves the equal state
  p_diff_leaves_eq_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == CMP_EQ && step_en && a_bit != b_bit) |=> st_q != CMP_EQ);

  // R8: idle cycles do not move the decision
  p_idle_state_r8: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(st_q));

  // R3: only legal encodings appear
  p_legal_code_r3: assert property (@(posedge clk) disable iff (rst)
    st_q != cmp_t'(2'b11));

endmodule

// File: rtl/fzs_bit_count.sv
module fzs_bit_count #(
  parameter int OP_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic step_en,
  output logic done
);

  localparam int CW = $clog2(OP_W + 1);
  localparam logic [CW-1:0] LAST = CW'(OP_W - 1);
  localparam logic [CW-1:0] FULL = CW'(OP_W);

  logic [CW-1:0] cnt_q;
  logic          at_last;
  logic          saturated;

  assign at_last   = (cnt_q == LAST);
  assign saturated = (cnt_q == FULL);
  assign done      = step_en && at_last;

  always_ff @(posedge clk) begin
    if (rst)                        cnt_q <= '0;
    else if (step_en && !saturated) cnt_q <= cnt_q + 1'b1;
  end

  // R7: done is a single pulse per operation
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: the count never passes the operand width
  p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL);

  // R8: idle cycles do not advance the count
  p_idle_count_r8: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(cnt_q));

endmodule

// File: rtl/fzs_out_sel.sv
module fzs_out_sel
  import fzs_pkg::*;
(
  input  logic en,
  input  sel_t sel,
  input  cmp_t decide,
  input  logic a_bit,
  input  logic b_bit,
  output logic out_bit
);

  always_comb begin
    out_bit = 1'b0;
    if (en) out_bit = pick_bit(sel, decide, a_bit, b_bit);
  end

endmodule

// File: rtl/fzs_serial_maxmin.sv
module fzs_serial_maxmin
  import fzs_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic a_bit,
  input  logic b_bit,
  input  logic mode,
  input  logic bit_valid,
  output logic out_bit,
  output logic done
);

  // Named internal events for checking.
  logic step_en;
  cmp_t st_q;
  cmp_t decide;
  sel_t sel;

  assign step_en = bit_valid && !rst;
  assign sel     = sel_t'(mode);

  fzs_cmp_track u_track (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .a_bit   (a_bit),
    .b_bit   (b_bit),
    .st_q    (st_q),
    .decide  (decide)
  );

  fzs_bit_count #(.OP_W(OP_W)) u_count (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .done    (done)
  );

  fzs_out_sel u_sel (
    .en      (step_en),
    .sel     (sel),
    .decide  (decide),
    .a_bit   (a_bit),
    .b_bit   (b_bit),
    .out_bit (out_bit)
  );

  // R4: maximum forwards A once A is greater
  p_max_agt_r4: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !mode && decide == CMP_AGT) |-> out_bit == a_bit);

  // R5: minimum forwards A once A is less
  p_min_alt_r5: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && mode && decide == CMP_ALT) |-> out_bit == a_bit);

  // R6: the deciding pair already yields 1 for maximum
  p_first_diff_max_r6: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !mode && st_q == CMP_EQ && a_bit != b_bit) |-> out_bit);

  // R6: the deciding pair already yields 0 for minimum
  p_first_diff_min_r6: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && mode && st_q == CMP_EQ && a_bit != b_bit) |-> !out_bit);

  // R8: outputs stay low on idle cycles
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |-> (!out_bit && !done));

endmodule

// File: tb/fzs_serial_maxmin_tb_top.sv
module fzs_serial_maxmin_tb_top;

  localparam int OPW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_bit = 1'b0;
  logic b_bit = 1'b0;
  logic mode = 1'b0;
  logic bit_valid = 1'b0;
  logic out_bit;
  logic done;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  fzs_serial_maxmin #(.OP_W(OPW)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .a_bit     (a_bit),
    .b_bit     (b_bit),
    .mode      (mode),
    .bit_valid (bit_valid),
    .out_bit   (out_bit),
    .done      (done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference: larger or smaller grade as unsigned values.
  function automatic logic [OPW-1:0] ref_result(logic [OPW-1:0] a, logic [OPW-1:0] b, logic m);
    if (m) return (a < b) ? a : b;
    return (a > b) ? a : b;
  endfunction

  task automatic reset_cycle(input logic v, input logic a, input logic b);
    @(negedge clk);
    rst = 1'b1; bit_valid = v; a_bit = a; b_bit = b;
    #1;
    chk("R1 out_bit during reset", out_bit, 0);
    chk("R1 done during reset", done, 0);
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    rst = 1'b0; bit_valid = 1'b0;
    a_bit = 1'($urandom); b_bit = 1'($urandom);
    #1;
    chk("R8 out_bit idle", out_bit, 0);
    chk("R8 done idle", done, 0);
  endtask

  task automatic run_op(input logic [OPW-1:0] a, input logic [OPW-1:0] b,
                        input logic m, input bit gaps, input bit extra);
    logic [OPW-1:0] r;
    r = ref_result(a, b, m);
    reset_cycle(1'b0, 1'b0, 1'b0);
    mode = m;
    for (int i = OPW - 1; i >= 0; i--) begin
      if (gaps && ($urandom % 3 == 0)) idle_cycle();
      @(negedge clk);
      rst = 1'b0; bit_valid = 1'b1; a_bit = a[i]; b_bit = b[i];
      #1;
      chk(m ? "R5 min bit" : "R4 max bit", out_bit, r[i]);
      chk("R7 done timing", done, (i == 0) ? 1 : 0);
    end
    if (extra && a != b) begin
      @(negedge clk);
      a_bit = 1'($urandom); b_bit = 1'($urandom);
      #1;
      chk("R3 held decision after done",
          out_bit, ((a > b) ^ m) ? a_bit : b_bit);
      chk("R7 no second done", done, 0);
    end
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state with valid low
    reset_cycle(1'b0, 1'b1, 1'b0);
    // R1: reset with valid high must not decide or count
    reset_cycle(1'b1, 1'b1, 1'b0);
    mode = 1'b0;
    for (int i = OPW - 1; i >= 0; i--) begin
      @(negedge clk);
      rst = 1'b0; bit_valid = 1'b1;
      a_bit = (i < OPW / 2); b_bit = (i >= OPW / 2);
      #1;
      chk("R1 reset ignored valid pair (max stream)", out_bit, (i >= OPW / 2) ? 1 : 0);
      chk("R1 count cleared by reset", done, (i == 0) ? 1 : 0);
    end
    // R2: equal operands
    run_op(8'h5A, 8'h5A, 1'b0, 1'b0, 1'b0);
    run_op(8'hC3, 8'hC3, 1'b1, 1'b1, 1'b0);
    run_op(8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    run_op(8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0);
    // R6: decision at MSB and at LSB
    run_op(8'h80, 8'h7F, 1'b0, 1'b0, 1'b1);
    run_op(8'h80, 8'h7F, 1'b1, 1'b0, 1'b1);
    run_op(8'h00, 8'h01, 1'b0, 1'b0, 1'b1);
    run_op(8'h01, 8'h00, 1'b1, 1'b0, 1'b1);
    // Constrained random operations
    for (int k = 0; k < 80; k++) begin
      logic [OPW-1:0] ra, rb;
      ra = OPW'($urandom);
      rb = (k % 5 == 0) ? ra ^ OPW'(1 << ($urandom % OPW)) : OPW'($urandom);
      run_op(ra, rb, 1'($urandom), 1'b1, 1'($urandom));
    end
    // R8: a gap run with state preserved across idle cycles
    run_op(8'h3C, 8'h3D, 1'b1, 1'b1, 1'b1);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule